// File: doc/BRIEF.md
# Byte-Handshaked I2C Master Controller

This block is an I2C bus master driven by software through five 8-bit registers on a simple memory-mapped bus. Software picks a direction, loads a target address byte into the data register and writes the start bit of the status register. The block then emits START and clocks out the address. Every later byte is moved one at a time. At the end of each byte the block sets a sticky pending flag and raises its interrupt line. SCL stays low until software clears the flag, and clearing the flag launches the next byte.

SCL and SDA are open-drain style outputs, where 0 pulls the line low and 1 releases it. SCL is derived from the system clock by a fixed divider, and every bit lasts four equal phases. Target clock stretching, arbitration and slave operation are not handled. The line-control register is stored and read back only.

Top module: `i2cm_ctrl`

## Requirements
- R1: After reset the control (0x00), status (0x04) and line-control (0x10) registers read 0x00, the own-address (0x08) and data (0x0C) registers read 0xFF, and irq_o is 0. A read of any other offset returns 0x00.
- R2: The line-control register stores any written byte. Writes to the own-address register take effect only while status bit 4 (output enable) is 0. Writes to the data register take effect only while it is 1.
- R3: A status write with bit 4 = 1, bit 7 = 1 (master) and bit 5 = 1 clears status bit 0, sets bit 5 (busy), issues START and sends the data register byte (bits 7:1 target address, bit 0 = 1 for read).
- R4: After a transmitted byte, status bit 0 is 1 if the target NACKed while control bit 7 (ACK generation) is 1, and 0 otherwise.
- R5: At the end of each transferred byte, control bit 4 (pending) is set and irq_o rises, but only when control bit 5 (interrupt enable) is 1. irq_o is never 1 while pending is 0.
- R6: A control write never sets pending. Writing 0 to pending while it is 1 clears it and drops irq_o. If the written interrupt enable is 0, busy is cleared. Otherwise, if busy is set, the next byte starts: a transmit of the data register in mode 3 (status bits 7:6) or a receive in mode 2.
- R7: In mode 2, an ACKed address is followed at once by a received byte, with no pending set in between. The received byte is in the data register when pending is set. The ACK bit driven after a received byte is 0 when ACK generation was 1 at launch, and 1 otherwise.
- R8: A status write in master mode with bit 5 = 0 issues STOP. Busy is cleared only if pending is 0.
- R9: A status write with bit 4 = 0 clears busy, drops irq_o and releases both lines.
- R10: SDA changes while SCL is high only as START (falling) or STOP (rising). SCL is held low between bytes, and both lines are released after STOP.
- R11: During a byte, consecutive SCL rising edges are 4*QDIV clock cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write when 1, read when 0 |
| addr_i | input | ADDR_W | Byte offset of the register |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| irq_o | output | 1 | Interrupt request |
| scl_o | output | 1 | SCL drive: 0 pulls low, 1 releases |
| sda_o | output | 1 | SDA drive: 0 pulls low, 1 releases |
| sda_i | input | 1 | Sensed SDA line level |

## Verification
The assertions assume that software never writes the control or status register while a byte or a START/STOP sequence is being shifted. Under that assumption a byte completion cannot coincide with a register write, and every command reaches an engine that is ready. The stimulus keeps to this rule: after every byte-launching write it waits for irq_o, or for a fixed interval longer than a byte, before the next write. Register reads may occur at any time and have no side effects. A behavioural target model on the lines supplies ACKs, NACKs and read data.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  localparam int unsigned OFF_CTRL = 'h00;
  localparam int unsigned OFF_STAT = 'h04;
  localparam int unsigned OFF_OWN  = 'h08;
  localparam int unsigned OFF_DATA = 'h0C;
  localparam int unsigned OFF_LINE = 'h10;

  localparam int unsigned CTRL_ACKGEN = 7;
  localparam int unsigned CTRL_IE     = 5;
  localparam int unsigned CTRL_PEND   = 4;
  localparam int unsigned STAT_MST    = 7;
  localparam int unsigned STAT_BUSY   = 5;
  localparam int unsigned STAT_OE     = 4;
  localparam int unsigned STAT_NACK   = 0;

  localparam logic [1:0] MODE_RX = 2'b10;
  localparam logic [1:0] MODE_TX = 2'b11;

  typedef enum logic [2:0] {
    CMD_NONE, CMD_START, CMD_WRITE, CMD_READ, CMD_STOP
  } eng_cmd_e;

  typedef enum logic [2:0] {
    ES_IDLE, ES_START, ES_BITS, ES_STOP, ES_HOLD
  } eng_state_e;
endpackage

// File: rtl/i2cm_tick_gen.sv
module i2cm_tick_gen #(
  parameter int unsigned DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  logic [CW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == CW'(DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/i2cm_bit_engine.sv
module i2cm_bit_engine import i2cm_pkg::*; #(
  parameter int unsigned QDIV = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  eng_cmd_e   cmd_i,
  input  logic [7:0] tx_i,
  input  logic       ack_out_i,
  input  logic       abort_i,
  input  logic       sda_i,
  output logic       ready_o,
  output logic       done_o,
  output logic [7:0] rx_o,
  output logic       nack_o,
  output eng_state_e st_o,
  output logic       scl_o,
  output logic       sda_o
);
  eng_state_e st_q;
  logic [1:0] qtr_q;
  logic [3:0] bit_q;
  logic [7:0] sh_q;
  logic       rd_q, ack_out_q, nack_q, rs_q, tick;
  logic       scl_d, sda_d, bit_sda, last_bit;

  i2cm_tick_gen #(.DIV(QDIV)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (st_q inside {ES_START, ES_BITS, ES_STOP}),
    .tick_o(tick)
  );

  assign ready_o  = (st_q == ES_IDLE) || (st_q == ES_HOLD);
  assign last_bit = (bit_q == 4'd8);
  assign rx_o     = sh_q;
  assign nack_o   = nack_q;
  assign st_o     = st_q;
  assign bit_sda  = last_bit ? (rd_q ? ack_out_q : 1'b1) : (rd_q ? 1'b1 : sh_q[7]);

  always_comb begin
    scl_d = 1'b1;
    sda_d = 1'b1;
    case (st_q)
      ES_HOLD:  scl_d = 1'b0;
      ES_START: begin
        scl_d = (qtr_q == 2'd0) ? !rs_q : (qtr_q != 2'd3);
        sda_d = !qtr_q[1];
      end
      ES_BITS: begin
        scl_d = (qtr_q == 2'd1) || (qtr_q == 2'd2);
        sda_d = bit_sda;
      end
      ES_STOP: begin
        scl_d = (qtr_q != 2'd0);
        sda_d = qtr_q[1];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ES_IDLE;
      qtr_q     <= '0;
      bit_q     <= '0;
      sh_q      <= '0;
      rd_q      <= 1'b0;
      ack_out_q <= 1'b1;
      nack_q    <= 1'b0;
      rs_q      <= 1'b0;
      done_o    <= 1'b0;
      scl_o     <= 1'b1;
      sda_o     <= 1'b1;
    end else begin
      done_o <= 1'b0;
      scl_o  <= scl_d;
      sda_o  <= sda_d;
      if (abort_i) begin
        st_q  <= ES_IDLE;
        qtr_q <= '0;
      end else begin
        case (st_q)
          ES_IDLE, ES_HOLD: begin
            qtr_q <= '0;
            bit_q <= '0;
            case (cmd_i)
              CMD_START: begin
                st_q <= ES_START; sh_q <= tx_i; rd_q <= 1'b0; rs_q <= (st_q == ES_HOLD);
              end
              CMD_WRITE: begin st_q <= ES_BITS; sh_q <= tx_i; rd_q <= 1'b0; end
              CMD_READ:  begin st_q <= ES_BITS; rd_q <= 1'b1; ack_out_q <= ack_out_i; end
              CMD_STOP:  if (st_q == ES_HOLD) st_q <= ES_STOP;
              default: ;
            endcase
          end
          ES_START: if (tick) begin
            qtr_q <= qtr_q + 1'b1;
            if (qtr_q == 2'd3) begin st_q <= ES_BITS; bit_q <= '0; end
          end
          ES_BITS: if (tick) begin
            qtr_q <= qtr_q + 1'b1;
            if (qtr_q == 2'd2) begin
              if (last_bit)  nack_q <= sda_i;
              else if (rd_q) sh_q   <= {sh_q[6:0], sda_i};
            end
            if (qtr_q == 2'd3) begin
              if (last_bit) begin
                st_q   <= ES_HOLD;
                done_o <= 1'b1;
              end else begin
                bit_q <= bit_q + 1'b1;
                if (!rd_q) sh_q <= {sh_q[6:0], 1'b0};
              end
            end
          end
          ES_STOP: if (tick) begin
            qtr_q <= qtr_q + 1'b1;
            if (qtr_q == 2'd3) st_q <= ES_IDLE;
          end
          default: st_q <= ES_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2cm_ctrl.sv
module i2cm_ctrl import i2cm_pkg::*; #(
  parameter int unsigned QDIV   = 4,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic              irq_o,
  output logic              scl_o,
  output logic              sda_o,
  input  logic              sda_i
);
  logic [7:0] con_q, stat_q, ds_q, own_q, line_q;
  logic       irq_q, addr_ph_q, rx_op_q, cmd_ack_q, abort_q;
  logic [7:0] cmd_tx_q;
  eng_cmd_e   cmd_q;
  logic       eng_ready, eng_done, eng_nack;
  logic [7:0] eng_rx;
  eng_state_e eng_st;
  logic       wr;
  logic [1:0] mode;

  assign wr    = sel_i && we_i;
  assign mode  = stat_q[7:6];
  assign irq_o = irq_q;

  i2cm_bit_engine #(.QDIV(QDIV)) u_eng (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cmd_i    (cmd_q),
    .tx_i     (cmd_tx_q),
    .ack_out_i(cmd_ack_q),
    .abort_i  (abort_q),
    .sda_i    (sda_i),
    .ready_o  (eng_ready),
    .done_o   (eng_done),
    .rx_o     (eng_rx),
    .nack_o   (eng_nack),
    .st_o     (eng_st),
    .scl_o    (scl_o),
    .sda_o    (sda_o)
  );

  always_comb begin
    rdata_o = 8'h00;
    if (addr_i == ADDR_W'(OFF_CTRL))      rdata_o = con_q;
    else if (addr_i == ADDR_W'(OFF_STAT)) rdata_o = stat_q;
    else if (addr_i == ADDR_W'(OFF_OWN))  rdata_o = own_q;
    else if (addr_i == ADDR_W'(OFF_DATA)) rdata_o = ds_q;
    else if (addr_i == ADDR_W'(OFF_LINE)) rdata_o = line_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      con_q     <= 8'h00;
      stat_q    <= 8'h00;
      ds_q      <= 8'hFF;
      own_q     <= 8'hFF;
      line_q    <= 8'h00;
      irq_q     <= 1'b0;
      addr_ph_q <= 1'b0;
      rx_op_q   <= 1'b0;
      cmd_q     <= CMD_NONE;
      cmd_tx_q  <= 8'h00;
      cmd_ack_q <= 1'b1;
      abort_q   <= 1'b0;
    end else begin
      cmd_q   <= CMD_NONE;
      abort_q <= 1'b0;
      if (wr) begin
        if (addr_i == ADDR_W'(OFF_CTRL)) begin
          con_q <= {wdata_i[7:5], con_q[CTRL_PEND], wdata_i[3:0]};
          if (con_q[CTRL_PEND] && !wdata_i[CTRL_PEND]) begin
            con_q[CTRL_PEND] <= 1'b0;
            irq_q            <= 1'b0;
            if (!wdata_i[CTRL_IE]) begin
              stat_q[STAT_BUSY] <= 1'b0;
            end else if (stat_q[STAT_BUSY]) begin
              if (mode == MODE_TX) begin
                cmd_q <= CMD_WRITE; cmd_tx_q <= ds_q; rx_op_q <= 1'b0;
              end else if (mode == MODE_RX) begin
                cmd_q <= CMD_READ; cmd_ack_q <= !wdata_i[CTRL_ACKGEN]; rx_op_q <= 1'b1;
              end
            end
          end
        end else if (addr_i == ADDR_W'(OFF_STAT)) begin
          stat_q <= {wdata_i[7:6], stat_q[STAT_BUSY], wdata_i[4:0]};
          if (!wdata_i[STAT_OE]) begin
            stat_q[STAT_BUSY] <= 1'b0;
            irq_q             <= 1'b0;
            abort_q           <= 1'b1;
          end else if (wdata_i[STAT_MST]) begin
            if (wdata_i[STAT_BUSY]) begin
              stat_q[STAT_NACK] <= 1'b0;
              stat_q[STAT_BUSY] <= 1'b1;
              cmd_q             <= CMD_START;
              cmd_tx_q          <= ds_q;
              addr_ph_q         <= 1'b1;
              rx_op_q           <= 1'b0;
            end else begin
              cmd_q <= CMD_STOP;
              if (!con_q[CTRL_PEND]) stat_q[STAT_BUSY] <= 1'b0;
            end
          end
        end else if (addr_i == ADDR_W'(OFF_OWN)) begin
          if (!stat_q[STAT_OE]) own_q <= wdata_i;
        end else if (addr_i == ADDR_W'(OFF_DATA)) begin
          if (stat_q[STAT_OE]) ds_q <= wdata_i;
        end else if (addr_i == ADDR_W'(OFF_LINE)) begin
          line_q <= wdata_i;
        end
      end
      if (eng_done) begin
        if (addr_ph_q && !(eng_nack && con_q[CTRL_ACKGEN]) && mode == MODE_RX) begin
          // acked read address: chain the first data byte without an interrupt
          addr_ph_q <= 1'b0;
          cmd_q     <= CMD_READ;
          cmd_ack_q <= !con_q[CTRL_ACKGEN];
          rx_op_q   <= 1'b1;
        end else begin
          addr_ph_q <= 1'b0;
          if (rx_op_q) begin
            ds_q              <= eng_rx;
            stat_q[STAT_NACK] <= 1'b0;
          end else begin
            stat_q[STAT_NACK] <= eng_nack && con_q[CTRL_ACKGEN];
          end
          if (con_q[CTRL_IE]) begin
            con_q[CTRL_PEND] <= 1'b1;
            irq_q            <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/i2cm_ctrl_chk.sv
module i2cm_ctrl_chk import i2cm_pkg::*; #(
  parameter int unsigned ADDR_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [7:0]        wdata_i,
  input logic              irq_i,
  input logic              scl_i,
  input logic              sda_i,
  input logic [7:0]        con_i,
  input logic [7:0]        stat_i,
  input logic [7:0]        ds_i,
  input logic [7:0]        own_i,
  input logic              done_i,
  input logic              ready_i,
  input eng_cmd_e          cmd_i,
  input eng_state_e        st_i
);
  logic w_ctrl, w_stat, w_own, w_data;
  assign w_ctrl = wr_i && (addr_i == ADDR_W'(OFF_CTRL));
  assign w_stat = wr_i && (addr_i == ADDR_W'(OFF_STAT));
  assign w_own  = wr_i && (addr_i == ADDR_W'(OFF_OWN));
  assign w_data = wr_i && (addr_i == ADDR_W'(OFF_DATA));

  a_r5_irq_implies_pend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> con_i[CTRL_PEND]);

  a_r6_no_sw_pend_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (w_ctrl && !con_i[CTRL_PEND] && !done_i) |=> !con_i[CTRL_PEND]);

  a_r2_data_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (w_data && !stat_i[STAT_OE] && !done_i) |=> $stable(ds_i));

  a_r2_own_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (w_own && stat_i[STAT_OE]) |=> $stable(own_i));

  a_r9_oe_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (w_stat && !wdata_i[STAT_OE] && !done_i) |=> (!irq_i && !stat_i[STAT_BUSY]));

  a_r8_stop_keeps_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (w_stat && wdata_i[STAT_OE] && wdata_i[STAT_MST] && !wdata_i[STAT_BUSY]
     && con_i[CTRL_PEND] && stat_i[STAT_BUSY]) |=> stat_i[STAT_BUSY]);

  a_r10_sda_stable_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_i && $past(scl_i) && (sda_i != $past(sda_i))) |-> (st_i != ES_BITS));

  a_r3_cmd_when_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i != CMD_NONE) |-> ready_i);
endmodule

bind i2cm_ctrl i2cm_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .wr_i   (wr),
  .addr_i (addr_i),
  .wdata_i(wdata_i),
  .irq_i  (irq_o),
  .scl_i  (scl_o),
  .sda_i  (sda_o),
  .con_i  (con_q),
  .stat_i (stat_q),
  .ds_i   (ds_q),
  .own_i  (own_q),
  .done_i (eng_done),
  .ready_i(eng_ready),
  .cmd_i  (cmd_q),
  .st_i   (eng_st)
);

// File: tb/i2cm_ctrl_tb_top.sv
`timescale 1ns/1ps
module i2cm_ctrl_tb_top;
  localparam int QDIV = 4;
  localparam int AW   = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic irq, scl_o, sda_o;
  logic s_drv = 1'b1;
  logic sda_line;

  always #10 clk = ~clk;
  assign sda_line = sda_o & s_drv;

  i2cm_ctrl #(.QDIV(QDIV), .ADDR_W(AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .scl_o(scl_o),
    .sda_o(sda_o), .sda_i(sda_line)
  );

  int vec = 0, fails = 0;
  bit finished = 0;

  task automatic check(string req, int act, int exp);
    vec++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // ---------------- behavioural target on the lines ----------------
  typedef enum {S_IDLE, S_ADDR, S_WDATA, S_RDATA} s_st_e;
  s_st_e s_st = S_IDLE;
  int s_bit = 0, s_idx = 0, s_starts = 0, s_stops = 0;
  logic [7:0] s_sh = 0;
  logic s_rw = 0;
  logic [7:0] s_src [2] = '{8'hC3, 8'h5A};
  logic [7:0] s_got [$];
  logic s_mack [$];

  always @(negedge sda_line) if (scl_o === 1'b1) begin
    s_st = S_ADDR; s_bit = -1; s_starts++;
  end
  always @(posedge sda_line) if (scl_o === 1'b1 && rst_n) begin
    s_st = S_IDLE; s_drv = 1'b1; s_stops++;
  end
  always @(posedge scl_o) begin
    if ((s_st == S_ADDR || s_st == S_WDATA) && s_bit >= 0 && s_bit < 8) s_sh = {s_sh[6:0], sda_line};
    if (s_st == S_RDATA && s_bit == 8) s_mack.push_back(sda_line);
  end
  always @(negedge scl_o) if (s_st != S_IDLE) begin
    s_bit++;
    if (s_bit == 8) begin
      if (s_st == S_ADDR) begin
        if (s_sh[7:1] == 7'h2A) begin s_drv = 1'b0; s_rw = s_sh[0]; end
        else begin s_drv = 1'b1; s_st = S_IDLE; end
      end else if (s_st == S_WDATA) begin
        s_got.push_back(s_sh); s_drv = 1'b0;
      end else begin
        s_drv = 1'b1; s_idx++;
      end
    end else if (s_bit == 9) begin
      s_bit = 0; s_drv = 1'b1;
      if (s_st == S_ADDR) s_st = s_rw ? S_RDATA : S_WDATA;
      else if (s_st == S_RDATA && s_mack.size() > 0 && s_mack[$] == 1'b1) s_st = S_IDLE;
    end
    if (s_st == S_RDATA && s_bit < 8) s_drv = s_src[s_idx % 2][7 - s_bit];
  end

  // ---------------- line monitor ----------------
  int cyc = 0, last_rise = -1, min_gap = 1 << 30, hi_falls = 0, hi_rises = 0;
  logic p_scl = 1'b1, p_sda = 1'b1;
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (p_scl && scl_o && (p_sda != sda_line)) begin
        if (sda_line) hi_rises++; else hi_falls++;
      end
      if (!p_scl && scl_o) begin
        if (last_rise >= 0 && (cyc - last_rise) < min_gap) min_gap = cyc - last_rise;
        last_rise = cyc;
      end
    end
    p_scl = scl_o; p_sda = sda_line;
  end

  // ---------------- register reference model ----------------
  logic [7:0] e_con = 0, e_stat = 0, e_ds = 8'hFF, e_own = 8'hFF, e_line = 0;
  logic e_irq = 0;

  task automatic m_write(int a, logic [7:0] v);
    logic pend;
    case (a)
      'h00: begin
        pend = e_con[4];
        e_con = {v[7:5], pend, v[3:0]};
        if (pend && !v[4]) begin
          e_con[4] = 0; e_irq = 0;
          if (!v[5]) e_stat[5] = 0;
        end
      end
      'h04: begin
        e_stat = {v[7:6], e_stat[5], v[4:0]};
        if (!v[4]) begin e_stat[5] = 0; e_irq = 0; end
        else if (v[7]) begin
          if (v[5]) begin e_stat[0] = 0; e_stat[5] = 1; end
          else if (!e_con[4]) e_stat[5] = 0;
        end
      end
      'h08: if (!e_stat[4]) e_own = v;
      'h0C: if (e_stat[4]) e_ds = v;
      'h10: e_line = v;
      default: ;
    endcase
  endtask

  task automatic m_done(bit is_read, logic [7:0] rx, bit nack);
    if (is_read) begin e_ds = rx; e_stat[0] = 0; end
    else e_stat[0] = nack & e_con[7];
    if (e_con[5]) begin e_con[4] = 1; e_irq = 1; end
  endtask

  task automatic wr(int a, logic [7:0] v);
    @(negedge clk);
    sel = 1; we = 1; addr = AW'(a); wdata = v;
    @(posedge clk); #1;
    sel = 0; we = 0;
    m_write(a, v);
  endtask

  task automatic rd(int a, output logic [7:0] d);
    @(negedge clk);
    sel = 1; we = 0; addr = AW'(a);
    #2 d = rdata;
    @(posedge clk); #1;
    sel = 0;
  endtask

  task automatic chk_all(string req);
    logic [7:0] d;
    rd('h00, d); check({req, " control"}, d, e_con);
    rd('h04, d); check({req, " status"}, d, e_stat);
    rd('h08, d); check({req, " own-address"}, d, e_own);
    rd('h0C, d); check({req, " data"}, d, e_ds);
    rd('h10, d); check({req, " line-control"}, d, e_line);
    check({req, " irq"}, irq, e_irq);
  endtask

  task automatic wait_irq(string req);
    int n = 0;
    while (!irq && n < 3000) begin @(negedge clk); n++; end
    check({req, " irq arrival"}, irq, 1);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vec, fails);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state and unmapped offset
    chk_all("R1");
    rd('h14, d); check("R1 unmapped read", d, 0);
    rd('h18, d); check("R1 unmapped read", d, 0);
    check("R1 scl released", scl_o, 1);

    // R2 register gating
    wr('h10, 8'h5A);
    wr('h08, 8'h33);
    wr('h0C, 8'h12);
    wr('h00, 8'hA0);
    wr('h04, 8'hD0);        // R8 stop with idle bus: no busy
    wr('h08, 8'h77);
    wr('h0C, 8'h54);
    chk_all("R2");

    // R3 start + address write, R5 pending on ack
    wr('h04, 8'hF0);
    rd('h04, d); check("R3 busy set", d, 8'hF0);
    wait_irq("R5");
    m_done(0, 0, 0);
    chk_all("R3 R4 address acked");
    check("R10 scl held low between bytes", scl_o, 0);

    // R6 clearing pending launches the data byte
    wr('h0C, 8'h96);
    wr('h00, 8'hA0);
    check("R6 irq dropped", irq, 0);
    wait_irq("R6");
    m_done(0, 0, 0);
    chk_all("R6 data sent");
    check("R3 target got byte", (s_got.size() > 0) ? int'(s_got[0]) : -1, 8'h96);

    // R8 stop while pending keeps busy; R6 clear with IE=0 clears busy
    wr('h04, 8'hD0);
    chk_all("R8 busy kept");
    wr('h00, 8'h80);
    chk_all("R6 busy cleared");
    idle(100);
    check("R10 scl released after stop", scl_o, 1);
    check("R10 sda released after stop", sda_line, 1);

    // R4 NACKed address
    wr('h00, 8'hA0);
    wr('h0C, 8'h40);
    wr('h04, 8'hF0);
    wait_irq("R4");
    m_done(0, 0, 1);
    chk_all("R4 nack flag");
    wr('h04, 8'hD0);
    wr('h00, 8'h80);
    chk_all("R8 R4 after stop");
    idle(100);

    // R7 master receive
    wr('h00, 8'hA0);
    wr('h0C, 8'h55);
    wr('h04, 8'hB0);
    wait_irq("R7");
    m_done(1, 8'hC3, 0);
    chk_all("R7 first byte");
    wr('h00, 8'h20);         // ACK generation off: NACK the next byte
    wait_irq("R7");
    m_done(1, 8'h5A, 0);
    chk_all("R7 second byte");
    check("R7 ack after first byte", (s_mack.size() > 0) ? int'(s_mack[0]) : -1, 0);
    check("R7 nack after second byte", (s_mack.size() > 1) ? int'(s_mack[1]) : -1, 1);
    wr('h04, 8'h90);
    chk_all("R8 rx stop busy kept");
    wr('h00, 8'h00);
    chk_all("R8 rx stop busy cleared");
    idle(100);

    // R9 output enable off while pending
    wr('h00, 8'hA0);
    wr('h0C, 8'h40);
    wr('h04, 8'hF0);
    wait_irq("R9");
    m_done(0, 0, 1);
    wr('h04, 8'h00);
    chk_all("R9 oe off");
    idle(4);
    check("R9 scl released", scl_o, 1);
    check("R9 sda released", sda_line, 1);
    wr('h00, 8'hA0);
    chk_all("R9 pending cleared");

    // R5 no pending with interrupts disabled
    wr('h04, 8'hD0);
    wr('h00, 8'h80);
    wr('h0C, 8'h54);
    wr('h04, 8'hF0);
    idle(400);
    chk_all("R5 no pending with IE=0");
    wr('h04, 8'hD0);
    chk_all("R8 stop without pending");
    idle(100);

    // R10 line events, R11 bit period
    check("R10 start edges", hi_falls, 5);
    check("R10 stop edges", hi_rises, 4);
    check("R10 target starts", s_starts, 5);
    check("R11 scl period", min_gap, 4 * QDIV);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, fails);
    $finish;
  end
endmodule